// File: doc/BRIEF.md
# Asynchronous-Ready Bus Cycle Sequencer

This block is the bus master side of a memory port. An internal transfer engine hands it one access at a time: an address, a direction, write data, a flag saying more accesses of the same burst will follow, a burst kind, and a wait-state count. The sequencer turns each access into a series of bus clock states. The first is an address state, T1. One or more data/wait states, T2, follow. An idle state, Ti, is added only where needed. The cycle ends when an external ready line, which is not synchronised to the bus clock, is seen active.

Ready is captured on the falling edge of the bus clock. Ready seen during a state means the following T2 is the last one, so a zero-wait memory finishes in two clocks. The data strobe appears only in the extra T2 states of a cycle that waited. In a burst that keeps one direction, the read/write line holds its level for the whole burst. In a descriptor burst where a read is followed by a write, or a write by a read, one Ti state is placed between the two accesses, and the direction line flips at the start of that Ti.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset, and after reset applied in the middle of an access, the strobes (`bus_as`, `bus_ce`, `bus_ds`), `done`, `bus_doe` and `bus_dir` are all 0 and `req_ready` is 1.
- R2: Each access starts with exactly one T1 clock, in which `bus_as` and `bus_ce` are 1 and `bus_addr` carries the request address. Every later clock of the access is a T2, with `bus_as` and `bus_ce` at 0.
- R3: `bus_rdy` is taken only at the falling clock edge. A ready pulse that is high only around the falling edge of T1 ends the access after two clocks.
- R4: Number the clocks of an access from 0 at T1. Let r be the first clock whose falling edge sees ready high, and let w be the wait count (`req_wait`). The access then lasts max(r, w) + 2 clocks, up to and including its last T2. With w = 0, ready seen in T1 gives 2 clocks and ready first seen in the first T2 gives 3.
- R5: `bus_ds` is 1 in every T2 of an access except the first one, so it is never 1 in a two-clock access.
- R6: A wait count w of 0 to 3 forces at least w + 2 clocks. Ready seen in a clock numbered below w is ignored.
- R7: `bus_dir` is 1 for a write and 0 for a read. It takes its new level at the rising edge that starts the access (or its Ti), and it keeps that level through idle clocks until another access changes it.
- R8: In a burst of kind 0 (fixed direction), every access uses the direction of the first access of the burst. `req_write` is ignored on the later accesses, so such an access behaves as a read or a write purely by the burst direction.
- R9: In a burst of kind 1 (descriptor), an access whose direction differs from the previous access of the burst is preceded by one Ti clock. During Ti no strobe is active, and `bus_dir` already shows the new direction. An access with the same direction, or one not inside a burst, has no Ti.
- R10: For a write, `bus_doe` is 1 and `bus_dout` holds the write data from T1 through the clock after the last T2. It is 0 for reads. Read data is captured from `bus_din` at the rising edge that ends the last T2 and is shown on `rd_data` from then on.
- R11: `done` is 1 for exactly the one clock after the last T2. `req_ready` is 1 only while no access is in progress, including that `done` clock, in which the next request can be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | An access request is presented |
| req_ready | output | 1 | Sequencer idle; request taken this clock if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| req_burst | input | 1 | More accesses of this burst follow |
| req_kind | input | 1 | Burst kind: 0 fixed direction, 1 descriptor |
| req_wait | input | WAIT_W | Mandatory wait states for this access |
| done | output | 1 | One-clock pulse after an access ends |
| rd_data | output | DW | Captured read data |
| bus_addr | output | AW | Bus address |
| bus_as | output | 1 | Address strobe, active high |
| bus_ce | output | 1 | Chip-enable strobe, active high |
| bus_ds | output | 1 | Data strobe, active high |
| bus_dir | output | 1 | Direction line, 1 = write |
| bus_dout | output | DW | Write data to the bus |
| bus_doe | output | 1 | Write data output enable |
| bus_din | input | DW | Read data from the bus |
| bus_rdy | input | 1 | Asynchronous ready, active high |

## Verification
The assertions assume that the request fields stay stable while `req_valid` is high. They also assume that the burst kind does not change in the middle of a burst and that `req_wait` fits the configured width. The stimulus raises `req_valid` only in an idle clock and drops it right after the accepting edge. It changes `bus_rdy` and `bus_din` just after a rising edge, so every falling-edge sample sees a settled level. Under these assumptions, the strobe, direction and data-enable properties follow from the state sequence alone.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TI   = 2'd1,
    ST_T1   = 2'd2,
    ST_T2   = 2'd3
  } bus_state_e;

  typedef enum logic {
    KIND_BUF  = 1'b0,
    KIND_DESC = 1'b1
  } burst_kind_e;
endpackage

// File: rtl/bcs_rdy_sample.sv
module bcs_rdy_sample (
  input  logic clk,
  input  logic rst,
  input  logic rdy_async,
  output logic rdy_fall
);
  // capture on the falling edge: half a clock to settle before the FSM uses it
  always_ff @(negedge clk) begin
    if (rst) rdy_fall <= 1'b0;
    else     rdy_fall <= rdy_async;
  end
endmodule

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
  import bcs_pkg::*;
#(
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_burst,
  input  logic              req_kind,
  input  logic [WAIT_W-1:0] req_wait,
  input  logic              rdy_fall,
  output logic              req_ready,
  output logic              accept,
  output logic              t1_enter,
  output logic              end_edge,
  output logic              dir_next,
  output logic              dir_q,
  output logic              as_q,
  output logic              ce_q,
  output logic              ds_q,
  output logic              done_q
);
  bus_state_e        state_q, state_d;
  burst_kind_e       kind_q;
  logic [WAIT_W-1:0] k_q, wlat_q;
  logic              term_q, open_q;
  logic              buf_lock, eff_write, need_ti, honor;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign buf_lock  = open_q && (kind_q == KIND_BUF);
  assign eff_write = buf_lock ? dir_q : req_write;
  assign need_ti   = open_q && (kind_q == KIND_DESC) && (eff_write != dir_q);
  assign end_edge  = (state_q == ST_T2) && term_q;
  assign dir_next  = accept ? eff_write : dir_q;
  assign honor     = rdy_fall && (k_q >= wlat_q);
  assign t1_enter  = (state_d == ST_T1);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = need_ti ? ST_TI : ST_T1;
      ST_TI:   state_d = ST_T1;
      ST_T1:   state_d = ST_T2;
      ST_T2:   if (term_q) state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      kind_q  <= KIND_BUF;
      k_q     <= '0;
      wlat_q  <= '0;
      term_q  <= 1'b0;
      open_q  <= 1'b0;
      dir_q   <= 1'b0;
      as_q    <= 1'b0;
      ce_q    <= 1'b0;
      ds_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      dir_q   <= dir_next;
      as_q    <= (state_d == ST_T1);
      ce_q    <= (state_d == ST_T1);
      ds_q    <= (state_d == ST_T2) && (state_q == ST_T2);
      done_q  <= end_edge;
      if (accept) begin
        wlat_q <= req_wait;
        open_q <= req_burst;
        if (!open_q) kind_q <= burst_kind_e'(req_kind);
      end
      if (state_d == ST_T1) begin
        k_q    <= '0;
        term_q <= 1'b0;
      end else if (state_q == ST_T1 || (state_q == ST_T2 && !term_q)) begin
        term_q <= honor;
        if (k_q < wlat_q) k_q <= k_q + 1'b1;
      end
    end
  end

  // R2
  as_one_clk_chk: assert property (@(posedge clk) disable iff (rst) as_q |=> !as_q);
  // R5
  ds_after_t1_chk: assert property (@(posedge clk) disable iff (rst) as_q |=> !ds_q);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done_q |=> !done_q);
  // R7
  dir_hold_chk: assert property (@(posedge clk) disable iff (rst) (state_q == ST_T2) |-> $stable(dir_q));
  // R9
  ti_then_t1_chk: assert property (@(posedge clk) disable iff (rst) (state_q == ST_TI) |=> (as_q && ce_q));
endmodule

// File: rtl/bcs_data.sv
module bcs_data #(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          t1_enter,
  input  logic          end_edge,
  input  logic          dir_next,
  input  logic          dir_cur,
  input  logic          done_cur,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] bus_din,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wd_q,
  output logic [DW-1:0] rd_q,
  output logic          doe_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
      doe_q  <= 1'b0;
    end else begin
      if (accept) begin
        addr_q <= req_addr;
        wd_q   <= req_wdata;
      end
      if (end_edge && !dir_cur) rd_q <= bus_din;
      if (t1_enter)      doe_q <= dir_next;
      else if (done_cur) doe_q <= 1'b0;
    end
  end

  // R10
  doe_dir_chk: assert property (@(posedge clk) disable iff (rst) doe_q |-> dir_cur);
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq #(
  parameter int AW     = 24,
  parameter int DW     = 16,
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic              req_burst,
  input  logic              req_kind,
  input  logic [WAIT_W-1:0] req_wait,
  output logic              done,
  output logic [DW-1:0]     rd_data,
  output logic [AW-1:0]     bus_addr,
  output logic              bus_as,
  output logic              bus_ce,
  output logic              bus_ds,
  output logic              bus_dir,
  output logic [DW-1:0]     bus_dout,
  output logic              bus_doe,
  input  logic [DW-1:0]     bus_din,
  input  logic              bus_rdy
);
  logic rdy_fall, accept, t1_enter, end_edge, dir_next;

  bcs_rdy_sample u_rdy (
    .clk(clk), .rst(rst), .rdy_async(bus_rdy), .rdy_fall(rdy_fall)
  );

  bcs_ctrl #(.WAIT_W(WAIT_W)) u_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_burst(req_burst), .req_kind(req_kind), .req_wait(req_wait),
    .rdy_fall(rdy_fall), .req_ready(req_ready), .accept(accept),
    .t1_enter(t1_enter), .end_edge(end_edge), .dir_next(dir_next),
    .dir_q(bus_dir), .as_q(bus_as), .ce_q(bus_ce), .ds_q(bus_ds), .done_q(done)
  );

  bcs_data #(.AW(AW), .DW(DW)) u_data (
    .clk(clk), .rst(rst), .accept(accept), .t1_enter(t1_enter),
    .end_edge(end_edge), .dir_next(dir_next), .dir_cur(bus_dir),
    .done_cur(done), .req_addr(req_addr), .req_wdata(req_wdata),
    .bus_din(bus_din), .addr_q(bus_addr), .wd_q(bus_dout), .rd_q(rd_data),
    .doe_q(bus_doe)
  );
endmodule

// File: tb/bus_cycle_seq_test.sv
`timescale 1ns/1ps
module bus_cycle_seq_test;
  localparam int AW = 24;
  localparam int DW = 16;
  localparam int WAIT_W = 2;
  localparam int NV = 8;

  typedef struct packed {
    logic        wr;
    logic [1:0]  w;
    logic [3:0]  rat;
    logic [3:0]  len;
    logic [15:0] wd;
  } vec_t;

  // write, wait count, first ready clock, expected length, write data
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd0, 4'd0, 4'd2, 16'h0000},
    '{1'b0, 2'd0, 4'd1, 4'd3, 16'h0000},
    '{1'b1, 2'd0, 4'd0, 4'd2, 16'h1234},
    '{1'b1, 2'd0, 4'd2, 4'd4, 16'hBEEF},
    '{1'b0, 2'd2, 4'd0, 4'd4, 16'h0000},
    '{1'b1, 2'd3, 4'd1, 4'd5, 16'h5A5A},
    '{1'b0, 2'd1, 4'd3, 4'd5, 16'h0000},
    '{1'b1, 2'd3, 4'd3, 4'd5, 16'hC0DE}
  };

  logic clk = 1'b0;
  logic rst, req_valid, req_ready, req_write, req_burst, req_kind;
  logic [AW-1:0] req_addr, bus_addr;
  logic [DW-1:0] req_wdata, rd_data, bus_dout, bus_din;
  logic [WAIT_W-1:0] req_wait;
  logic done, bus_as, bus_ce, bus_ds, bus_dir, bus_doe, bus_rdy;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  bus_cycle_seq #(.AW(AW), .DW(DW), .WAIT_W(WAIT_W)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_burst(req_burst), .req_kind(req_kind), .req_wait(req_wait),
    .done(done), .rd_data(rd_data), .bus_addr(bus_addr), .bus_as(bus_as),
    .bus_ce(bus_ce), .bus_ds(bus_ds), .bus_dir(bus_dir), .bus_dout(bus_dout),
    .bus_doe(bus_doe), .bus_din(bus_din), .bus_rdy(bus_rdy)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  // starts and returns one time unit after a rising edge
  task automatic access(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        input logic [1:0] w, input int rat, input int exp_len,
                        input logic burst, input logic kind, input logic exp_dir,
                        input logic exp_ti, input bit pulse, input string ltag);
    int done_idx = -1;
    chk(req_ready == 1'b1, "R11", req_ready, 1);
    req_write = wr; req_addr = a; req_wdata = wd; req_wait = w;
    req_burst = burst; req_kind = kind; req_valid = 1'b1; bus_rdy = 1'b0;
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (exp_ti) begin
      #5;
      chk(!bus_as && !bus_ce && !bus_ds, "R9", {bus_as, bus_ce, bus_ds}, 0);
      chk(bus_dir == exp_dir, "R9", bus_dir, exp_dir);
      @(posedge clk); #1;
    end
    for (int idx = 0; idx < 40; idx++) begin
      bus_din = 16'hA500 | 16'(idx);
      if (pulse) begin
        bus_rdy = 1'b0; #1;
        bus_rdy = (idx == rat); #3;
        bus_rdy = 1'b0; #1;
      end else begin
        bus_rdy = (idx >= rat); #5;
      end
      if (idx == 0) chk(bus_addr == a, "R2", int'(bus_addr), int'(a));
      chk(bus_as == (idx == 0) && bus_ce == (idx == 0), "R2", bus_as, idx == 0);
      chk(bus_ds == (idx >= 2 && idx < exp_len), "R5", bus_ds, idx >= 2 && idx < exp_len);
      chk(bus_dir == exp_dir, "R7", bus_dir, exp_dir);
      chk(bus_doe == exp_dir, "R10", bus_doe, exp_dir);
      chk(req_ready == done, "R11", req_ready, done);
      if (done) begin
        done_idx = idx;
        break;
      end
      @(posedge clk); #1;
    end
    chk(done_idx == exp_len, ltag, done_idx, exp_len);
    if (exp_dir) chk(bus_dout == wd, "R10", int'(bus_dout), int'(wd));
    else chk(rd_data == (16'hA500 | 16'(exp_len - 1)), "R10", int'(rd_data),
             int'(16'hA500 | 16'(exp_len - 1)));
    @(posedge clk); #1;
    bus_rdy = 1'b0;
    chk(done == 1'b0, "R11", done, 0);
    chk(bus_doe == 1'b0, "R10", bus_doe, 0);
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    req_burst = 1'b0; req_kind = 1'b0; req_wait = '0; bus_din = '0; bus_rdy = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(!bus_as && !bus_ce && !bus_ds && !done && !bus_doe && !bus_dir, "R1",
        {bus_as, bus_ce, bus_ds, done, bus_doe, bus_dir}, 0);
    chk(req_ready == 1'b1, "R1", req_ready, 1);
    rst = 1'b0;
    @(posedge clk); #1;

    // R4 R6: table of single accesses
    for (int i = 0; i < NV; i++)
      access(VEC[i].wr, 24'h100000 + AW'(i), VEC[i].wd, VEC[i].w, int'(VEC[i].rat),
             int'(VEC[i].len), 1'b0, 1'b0, VEC[i].wr, 1'b0, 1'b0, "R4/R6");

    // R3: ready high only around the falling edge of T1
    access(1'b0, 24'h200000, 16'h0, 2'd0, 0, 2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R3");
    // R3: ready pulse at the falling edge of the first T2
    access(1'b0, 24'h200004, 16'h0, 2'd0, 1, 3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R3");

    // R8: fixed-direction burst, write request inside a read burst acts as read
    access(1'b0, 24'h300000, 16'h0, 2'd0, 1, 3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
    access(1'b1, 24'h300002, 16'hFFFF, 2'd0, 0, 2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
    access(1'b0, 24'h300004, 16'h0, 2'd1, 0, 3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
    repeat (3) @(posedge clk);
    #1;
    chk(bus_dir == 1'b0, "R7", bus_dir, 0);

    // R9: descriptor burst read then write inserts Ti
    access(1'b0, 24'h400000, 16'h0, 2'd0, 0, 2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R9");
    access(1'b1, 24'h400010, 16'h7777, 2'd0, 1, 3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R9");
    // R9: same direction within the burst, no Ti
    access(1'b1, 24'h400012, 16'h8888, 2'd0, 0, 2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R9");
    // R9: write then read inserts Ti
    access(1'b0, 24'h400014, 16'h0, 2'd0, 0, 2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R9");
    // R9: direction change outside a burst, no Ti
    access(1'b1, 24'h400020, 16'h4242, 2'd0, 0, 2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R9");
    repeat (4) @(posedge clk);
    #1;
    chk(bus_dir == 1'b1, "R7", bus_dir, 1);

    // R1: reset in the middle of a write access
    req_write = 1'b1; req_addr = 24'h500000; req_wdata = 16'h9999; req_wait = 2'd3;
    req_burst = 1'b0; req_kind = 1'b0; req_valid = 1'b1; bus_rdy = 1'b0;
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(posedge clk); #1;
    rst = 1'b1;
    @(posedge clk); #1;
    chk(!bus_as && !bus_ce && !bus_ds && !done && !bus_doe && !bus_dir, "R1",
        {bus_as, bus_ce, bus_ds, done, bus_doe, bus_dir}, 0);
    chk(req_ready == 1'b1, "R1", req_ready, 1);
    rst = 1'b0;
    @(posedge clk); #1;

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule